// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating analog-to-digital converter. It divides the free-running oscillator clock into a slower conversion tick. It then runs a fixed frame of 4000 ticks in three phases: auto-zero, integrate and de-integrate. For each phase it raises one select output that drives the analog switches. The integrator, buffer, reference and comparator are outside the block. The only thing they return is one comparator bit, high when the integrator output sits above zero.

The integrate phase is always 1000 ticks long. On its last tick the comparator is sampled, which fixes the sign of the input. That sign picks which of the two de-integrate selects is driven, so the reference pulls the integrator back toward zero. De-integrate ends on the first tick at which the comparator has left its sampled level. The ticks counted before that point, kept in BCD, are the reading, and the reading equals 1000 times the input-to-reference ratio. If the comparator never flips, the block stops de-integrate after 2000 ticks and flags overrange. Auto-zero takes up whatever remains of the frame, so the frame length never changes.

Top module: `dual_slope_seq`

## Requirements
- R1: `convTick` is high for exactly one oscillator clock in every 4, and each conversion-tick state change happens on a clock edge where `convTick` is high.
- R2: While `rst` is high, at the following edge `phAz` is 1, the other three phase outputs are 0, the reading is 0, and `rdNeg` and `rdOver` are 0. After reset the first auto-zero lasts 3000 ticks.
- R3: Exactly one of `phAz`, `phInt`, `phDePos`, `phDeNeg` is high at any time. The phases always run in the order auto-zero, integrate, de-integrate, auto-zero.
- R4: Integrate lasts exactly 1000 ticks, which is 4000 oscillator clocks.
- R5: The comparator level on the last integrate tick selects the de-integrate output. High selects `phDePos` and gives `rdNeg`=0. Low selects `phDeNeg` and gives `rdNeg`=1. The selection holds for the whole de-integrate phase.
- R6: De-integrate ends on the first tick k (counting from 0) at which the comparator differs from the sampled level. It lasts k+1 ticks, and the latched reading is k.
- R7: Every frame is 4000 ticks (16000 oscillator clocks). Auto-zero after a reading of k lasts 2999-k ticks.
- R8: If the comparator has not changed after 2000 de-integrate ticks, de-integrate ends, `rdOver` is set, the reading shows 1999, and auto-zero lasts 1000 ticks. A normal end clears `rdOver`.
- R9: A reading of zero still reports the sign chosen at the end of integrate on `rdNeg`.
- R10: The reading is BCD: `rdThou` is the thousands bit, `rdDigits[11:8]` hundreds, `rdDigits[7:4]` tens, `rdDigits[3:0]` ones.
- R11: The reading, `rdNeg` and `rdOver` change only at the clock edge that ends de-integrate. They hold their values through auto-zero, integrate and de-integrate.
- R12: The comparator is ignored during auto-zero and during integrate, except on the last integrate tick. Toggling it there changes neither phase lengths nor the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| cmpIn | input | 1 | Comparator, high when integrator output is above zero |
| convTick | output | 1 | Conversion tick enable, one clock in 4 |
| phAz | output | 1 | Auto-zero switch select |
| phInt | output | 1 | Signal integrate switch select |
| phDePos | output | 1 | De-integrate select for a positive input |
| phDeNeg | output | 1 | De-integrate select for a negative input |
| rdDigits | output | 12 | Latched hundreds, tens, ones BCD digits |
| rdThou | output | 1 | Latched thousands bit |
| rdNeg | output | 1 | Latched sign, 1 for negative |
| rdOver | output | 1 | Latched overrange flag |

## Verification
The comparator is only observed on particular conversion ticks, so the hardest case to create is a crossing on one exact tick index. The bench drives no analog model. It watches `convTick` at falling edges inside de-integrate, counts tick edges, and flips the comparator just ahead of the chosen edge. This places the crossing on ticks 0, 7, 500, 1099 and 1999 and lets it never come for the overrange frame. Each phase length is then measured in oscillator clocks and compared against the frame arithmetic.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

  typedef enum logic [1:0] {
    PH_AZ  = 2'd0,
    PH_INT = 2'd1,
    PH_DE  = 2'd2
  } phase_e;

  // strobes from control to the count/result datapath, valid on a tick
  typedef struct packed {
    logic clr;    // zero the running count (entering de-integrate)
    logic inc;    // advance the running count by one
    logic latch;  // copy count and flags to the result latch
    logic over;   // de-integrate ended without a crossing
    logic neg;    // sampled input sign is negative
  } dp_strobe_t;

endpackage

// File: rtl/dsq_prescale.sv
module dsq_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] divCnt;

  always_ff @(posedge clk) begin
    if (rst)                 divCnt <= '0;
    else if (divCnt == LAST) divCnt <= '0;
    else                     divCnt <= divCnt + 1'b1;
  end

  assign tick = (divCnt == LAST);

endmodule

// File: rtl/dsq_ctrl.sv
module dsq_ctrl
  import dsq_pkg::*;
#(
  parameter int INT_TICKS   = 1000,
  parameter int FRAME_TICKS = 4000,
  parameter int DE_MAX      = 2000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       cmpIn,
  output phase_e     phase,
  output logic       polPos,
  output dp_strobe_t strb
);

  localparam int CW = $clog2(FRAME_TICKS);
  localparam logic [CW-1:0] AZ_LAST  = CW'(FRAME_TICKS - INT_TICKS - 1);
  localparam logic [CW-1:0] INT_LAST = CW'(INT_TICKS - 1);
  localparam logic [CW-1:0] DE_LAST  = CW'(DE_MAX - 1);

  logic [CW-1:0] phCnt;
  logic          crossed;
  logic          deDone;

  assign crossed = (cmpIn != polPos);
  assign deDone  = crossed || (phCnt == DE_LAST);

  // the count runs on through de-integrate into auto-zero, so auto-zero
  // absorbs exactly the ticks de-integrate did not use
  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_AZ;
      phCnt  <= '0;
      polPos <= 1'b1;
    end else if (tick) begin
      unique case (phase)
        PH_AZ: begin
          if (phCnt == AZ_LAST) begin
            phase <= PH_INT;
            phCnt <= '0;
          end else begin
            phCnt <= phCnt + 1'b1;
          end
        end
        PH_INT: begin
          if (phCnt == INT_LAST) begin
            phase  <= PH_DE;
            phCnt  <= '0;
            polPos <= cmpIn;
          end else begin
            phCnt <= phCnt + 1'b1;
          end
        end
        default: begin
          if (deDone) phase <= PH_AZ;
          phCnt <= phCnt + 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    strb.clr   = tick && (phase == PH_INT) && (phCnt == INT_LAST);
    strb.inc   = tick && (phase == PH_DE) && !deDone;
    strb.latch = tick && (phase == PH_DE) && deDone;
    strb.over  = !crossed;
    strb.neg   = !polPos;
  end

endmodule

// File: rtl/dsq_datapath.sv
module dsq_datapath
  import dsq_pkg::*;
#(
  parameter int NDEC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  dp_strobe_t        strb,
  output logic [4*NDEC-1:0] rdDigits,
  output logic              rdThou,
  output logic              rdNeg,
  output logic              rdOver
);

  logic [4*NDEC-1:0] cntBcd;
  logic [NDEC:0]     carry;
  logic              cntThou;

  always_comb begin
    carry[0] = strb.inc;
    for (int i = 0; i < NDEC; i++)
      carry[i+1] = carry[i] && (cntBcd[4*i +: 4] == 4'd9);
  end

  for (genvar g = 0; g < NDEC; g++) begin : g_dec
    logic [3:0] dig;
    always_ff @(posedge clk) begin
      if (rst || strb.clr) dig <= '0;
      else if (carry[g])   dig <= (dig == 4'd9) ? 4'd0 : dig + 4'd1;
    end
    assign cntBcd[4*g +: 4] = dig;
  end

  always_ff @(posedge clk) begin
    if (rst || strb.clr)   cntThou <= 1'b0;
    else if (carry[NDEC])  cntThou <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdDigits <= '0;
      rdThou   <= 1'b0;
      rdNeg    <= 1'b0;
      rdOver   <= 1'b0;
    end else if (strb.latch) begin
      rdDigits <= cntBcd;
      rdThou   <= cntThou;
      rdNeg    <= strb.neg;
      rdOver   <= strb.over;
    end
  end

endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dsq_pkg::*;
#(
  parameter int OSC_DIV     = 4,
  parameter int INT_TICKS   = 1000,
  parameter int FRAME_TICKS = 4000,
  parameter int DE_MAX      = 2000,
  parameter int NDEC        = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmpIn,
  output logic              convTick,
  output logic              phAz,
  output logic              phInt,
  output logic              phDePos,
  output logic              phDeNeg,
  output logic [4*NDEC-1:0] rdDigits,
  output logic              rdThou,
  output logic              rdNeg,
  output logic              rdOver
);

  phase_e     phase;
  logic       polPos;
  dp_strobe_t strb;

  dsq_prescale #(.DIV(OSC_DIV)) u_pre (
    .clk (clk),
    .rst (rst),
    .tick(convTick)
  );

  dsq_ctrl #(
    .INT_TICKS  (INT_TICKS),
    .FRAME_TICKS(FRAME_TICKS),
    .DE_MAX     (DE_MAX)
  ) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .tick  (convTick),
    .cmpIn (cmpIn),
    .phase (phase),
    .polPos(polPos),
    .strb  (strb)
  );

  dsq_datapath #(.NDEC(NDEC)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .rdDigits(rdDigits),
    .rdThou  (rdThou),
    .rdNeg   (rdNeg),
    .rdOver  (rdOver)
  );

  assign phAz    = (phase == PH_AZ);
  assign phInt   = (phase == PH_INT);
  assign phDePos = (phase == PH_DE) && polPos;
  assign phDeNeg = (phase == PH_DE) && !polPos;

endmodule

// File: rtl/dual_slope_seq_chk.sv
module dual_slope_seq_chk #(
  parameter int OSC_DIV   = 4,
  parameter int INT_TICKS = 1000,
  parameter int NDEC      = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              convTick,
  input logic              phAz,
  input logic              phInt,
  input logic              phDePos,
  input logic              phDeNeg,
  input logic [4*NDEC-1:0] rdDigits,
  input logic              rdThou,
  input logic              rdNeg,
  input logic              rdOver
);

  localparam int IW = $clog2(INT_TICKS * OSC_DIV) + 2;
  localparam logic [IW-1:0] INT_CLKS = IW'(INT_TICKS * OSC_DIV);
  localparam logic [4*NDEC-1:0] ALL_NINES = {NDEC{4'd9}};

  logic [IW-1:0] intClks;
  logic          inDe;

  assign inDe = phDePos || phDeNeg;

  always_ff @(posedge clk) begin
    if (rst)        intClks <= '0;
    else if (phInt) intClks <= intClks + 1'b1;
    else            intClks <= '0;
  end

  p_tick_single_r1: assert property (@(posedge clk) disable iff (rst)
    convTick |=> !convTick);

  p_onehot_phase_r3: assert property (@(posedge clk) disable iff (rst)
    $countones({phAz, phInt, phDePos, phDeNeg}) == 1);

  p_az_to_int_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(phAz) |-> phInt);

  p_int_to_de_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(phInt) |-> inDe);

  p_int_length_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(phInt) |-> (intClks == INT_CLKS));

  p_de_sign_hold_r5: assert property (@(posedge clk) disable iff (rst)
    phDePos |=> (phDePos || phAz));

  p_de_sign_hold_neg_r5: assert property (@(posedge clk) disable iff (rst)
    phDeNeg |=> (phDeNeg || phAz));

  p_over_value_r8: assert property (@(posedge clk) disable iff (rst)
    rdOver |-> (rdThou && rdDigits == ALL_NINES));

  p_result_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !inDe |=> $stable({rdThou, rdDigits, rdNeg, rdOver}));

endmodule

bind dual_slope_seq dual_slope_seq_chk #(
  .OSC_DIV  (OSC_DIV),
  .INT_TICKS(INT_TICKS),
  .NDEC     (NDEC)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .convTick(convTick),
  .phAz    (phAz),
  .phInt   (phInt),
  .phDePos (phDePos),
  .phDeNeg (phDeNeg),
  .rdDigits(rdDigits),
  .rdThou  (rdThou),
  .rdNeg   (rdNeg),
  .rdOver  (rdOver)
);

// File: tb/dual_slope_seq_bench.sv
`timescale 1ns/1ps
module dual_slope_seq_bench;

  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmpIn = 1'b0;
  logic        convTick, phAz, phInt, phDePos, phDeNeg;
  logic [11:0] rdDigits;
  logic        rdThou, rdNeg, rdOver;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 0;
  logic [12:0] prevRd = '0;

  always #10 clk = ~clk;

  dual_slope_seq u_dual_slope_seq (
    .clk(clk), .rst(rst), .cmpIn(cmpIn), .convTick(convTick),
    .phAz(phAz), .phInt(phInt), .phDePos(phDePos), .phDeNeg(phDeNeg),
    .rdDigits(rdDigits), .rdThou(rdThou), .rdNeg(rdNeg), .rdOver(rdOver)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 180000 && !done) begin
      done = 1;
      nFails++;
      $display("FAIL R7 watchdog: got %0d cycles expected under 180000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  function automatic logic [12:0] toBcd(int v);
    return {v >= 1000, 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    cmpIn = 1'b0;
    repeat (4) @(negedge clk);
    check(phAz && !phInt && !phDePos && !phDeNeg, "R2", "phase in reset",
          {phAz, phInt, phDePos, phDeNeg}, 4'b1000);
    check({rdThou, rdDigits} == 13'd0 && !rdNeg && !rdOver, "R2", "reading in reset",
          {rdOver, rdNeg, rdThou, rdDigits}, 0);
    rst = 1'b0;
    begin
      int ticks = 0;
      int clks  = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (convTick) ticks++;
      end
      check(ticks == 10, "R1", "ticks in 40 clocks", ticks, 10);
      clks = 40;
      while (!phInt) begin
        clks++;
        @(negedge clk);
      end
      check(clks == 3000 * DIV, "R2", "first auto-zero clocks", clks, 3000 * DIV);
    end
  endtask

  // entry: at the first falling edge where phInt is seen high
  task automatic t_frame(int k, bit pol, bit over, bit disturb, string name);
    int intC = 0;
    int deC  = 0;
    int azC  = 0;
    int j    = 0;
    int val  = over ? 1999 : k;
    int expDe = over ? 2000 * DIV : (k + 1) * DIV;
    int expAz = over ? 1000 * DIV : (2999 - k) * DIV;
    cmpIn = disturb ? ~pol : pol;
    while (phInt) begin
      intC++;
      if (disturb && intC == 3990) cmpIn = pol;
      @(negedge clk);
    end
    check(intC == 1000 * DIV, "R4", {name, " integrate clocks"}, intC, 1000 * DIV);
    check(phDePos == pol && phDeNeg == !pol, "R5", {name, " de-integrate select"},
          {phDePos, phDeNeg}, {pol, !pol});
    check({rdThou, rdDigits} == prevRd, "R11", {name, " reading held at de-integrate entry"},
          {rdThou, rdDigits}, prevRd);
    while (phDePos || phDeNeg) begin
      deC++;
      if (convTick) begin
        if (!over && j == k) cmpIn = ~pol;
        j++;
      end
      if (deC == 6)
        check({rdThou, rdDigits} == prevRd, "R11", {name, " reading held in de-integrate"},
              {rdThou, rdDigits}, prevRd);
      @(negedge clk);
    end
    check(deC == expDe, over ? "R8" : "R6", {name, " de-integrate clocks"}, deC, expDe);
    check(phAz, "R3", {name, " auto-zero follows de-integrate"}, phAz, 1);
    check({rdThou, rdDigits} == toBcd(val), "R10", {name, " BCD reading"},
          {rdThou, rdDigits}, toBcd(val));
    check(rdNeg == !pol, "R5", {name, " sign"}, rdNeg, !pol);
    check(rdOver == over, "R8", {name, " overrange flag"}, rdOver, over);
    if (k == 0 && !over)
      check(rdNeg == !pol && {rdThou, rdDigits} == 13'd0, "R9", {name, " signed zero"},
            {rdNeg, rdThou, rdDigits}, {!pol, 13'd0});
    prevRd = toBcd(val);
    while (!phInt) begin
      azC++;
      if (disturb) cmpIn = ~cmpIn;
      @(negedge clk);
    end
    check(azC == expAz, "R7", {name, " auto-zero clocks"}, azC, expAz);
    check(intC + deC + azC == 4000 * DIV, "R7", {name, " frame clocks"},
          intC + deC + azC, 4000 * DIV);
    if (disturb)
      check(azC == expAz && intC == 1000 * DIV, "R12", {name, " comparator noise ignored"},
            azC + intC, expAz + 1000 * DIV);
  endtask

  task automatic t_mid_positive();       t_frame(500, 1'b1, 1'b0, 1'b1, "mid positive, noisy comparator"); endtask
  task automatic t_zero_negative();      t_frame(0, 1'b0, 1'b0, 1'b0, "zero negative"); endtask
  task automatic t_carry_positive();     t_frame(1099, 1'b1, 1'b0, 1'b0, "decade carry positive"); endtask
  task automatic t_top_negative();       t_frame(1999, 1'b0, 1'b0, 1'b0, "full scale negative"); endtask
  task automatic t_overrange_positive(); t_frame(0, 1'b1, 1'b1, 1'b0, "overrange positive"); endtask
  task automatic t_small_negative();     t_frame(7, 1'b0, 1'b0, 1'b0, "small negative"); endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_mid_positive();
    t_zero_negative();
    t_carry_positive();
    t_top_negative();
    t_overrange_positive();
    t_small_negative();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule